// File: doc/BRIEF.md
# I2C Master Start Sequencer with Stuck-SDA Recovery

This block sits in front of an I2C master's byte engine and owns the moment at which the master claims the bus. When a start request is pending, it looks at the synchronized SDA level on a clock-period tick. If SDA is high, it drives the START condition straight away. If SDA is held low, a slave is probably stuck part-way through a byte. The block then releases SDA and clocks SCL, one tick low and one tick high per pulse. It samples SDA in every high phase, so the stuck device can shift out its remaining bits and let go of the line.

If SDA comes back high within the allowed number of pulses, the burst stops with SCL high and the block goes straight on into the START. If SDA is still low at the last allowed high phase, recovery has failed. The block pulses a clear to the external start-request bit and raises both the error flag and the start flag. Both flags are sticky and are cleared by write-one-to-clear inputs.

After a successful START, the block holds SCL and SDA low for the byte engine until the start request is withdrawn. Then it releases both lines. SDA and SCL drives are open-drain style: a 1 means the line is released and a 0 means it is pulled low.

Top module: `i2c_start_clear`

## Requirements
- R1: During and right after reset, scl_o and sda_o are 1 (released), err_flag, start_flag, start_req_clr and start_done are 0.
- R2: When start_req is high and sda_in is 1 on a tick in the idle state, the START is driven with no SCL pulse before it.
- R3: When sda_in is 0 at that check, SCL toggles with a low phase and a high phase of exactly one tick period each, and sda_o stays 1 for the whole burst.
- R4: If sda_in is 1 when sampled at the tick that ends a high phase, the burst stops with SCL high and the START follows. The number of SCL pulses equals the number of pulses the bus needed, up to and including pulse MAX_PULSES (default 9).
- R5: If sda_in is still 0 at the end of high phase MAX_PULSES, start_req_clr pulses for one cycle, no START is driven (sda_o stays 1), SCL is left at 1, and exactly MAX_PULSES pulses have been emitted.
- R6: A START is sda_o falling while scl_o is 1, with SCL held high for one tick period, then scl_o falls. start_done pulses for one cycle in the cycle that scl_o falls.
- R7: start_flag is set on every START and on every recovery failure, and err_flag only on failure. Both hold until cleared by a one-cycle high on clr_start or clr_err. A set in the same cycle as a clear wins.
- R8: After a START, scl_o and sda_o stay 0 until start_req drops, and then both return to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse marking one SCL phase period |
| start_req | input | 1 | Pending start request (level) |
| sda_in | input | 1 | Synchronized SDA line level |
| clr_err | input | 1 | Write-one-to-clear strobe for err_flag |
| clr_start | input | 1 | Write-one-to-clear strobe for start_flag |
| scl_o | output | 1 | SCL drive, 1 = released, 0 = pulled low |
| sda_o | output | 1 | SDA drive, 1 = released, 0 = pulled low |
| start_req_clr | output | 1 | One-cycle pulse clearing the start request on failure |
| start_done | output | 1 | One-cycle pulse when the START completes |
| err_flag | output | 1 | Sticky recovery-failure flag |
| start_flag | output | 1 | Sticky start-event flag |

## Verification
A flag can be set by the sequencer in the same cycle that software strobes its clear, and the two must resolve with the set winning. The bench provokes this by holding clr_start high through a whole transfer, so the clear strobe is high in the cycle that the START completes. At the start_done pulse, start_flag must read 1, and a few cycles later it must read 0 because the clear is still applied. A scoreboard compares the counted SCL pulses and the outcome of each transfer against a bus model that releases SDA after a chosen number of clock edges.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RLOW  = 3'd1,
    ST_RHIGH = 3'd2,
    ST_SETUP = 3'd3,
    ST_OWN   = 3'd4,
    ST_DRAIN = 3'd5
  } bc_state_t;

  localparam int unsigned FLAG_ERR   = 0;
  localparam int unsigned FLAG_START = 1;
  localparam int unsigned NUM_FLAGS  = 2;
endpackage

// File: rtl/i2c_bc_pulse_cnt.sv
module i2c_bc_pulse_cnt #(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned CW = $clog2(MAX_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '0;
    else if (clr)
      count <= '0;
    else if (inc && !at_limit)
      count <= count + 1'b1;
  end

  assign at_limit = (count == CW'(MAX_PULSES));
endmodule

// File: rtl/i2c_bc_flag.sv
module i2c_bc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set has priority over a coincident clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else if (set)
      q <= 1'b1;
    else if (clr)
      q <= 1'b0;
  end
endmodule

// File: rtl/i2c_bc_fsm.sv
module i2c_bc_fsm
  import i2c_bc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      start_req,
  input  logic      sda_in,
  input  logic      at_limit,
  output logic      cnt_clr,
  output logic      cnt_inc,
  output logic      ev_start,
  output logic      ev_fail,
  output logic      scl_o,
  output logic      sda_o,
  output logic      start_done,
  output logic      req_clr,
  output bc_state_t state
);
  bc_state_t nxt;
  logic      scl_n, sda_n;

  always_comb begin
    nxt      = state;
    scl_n    = scl_o;
    sda_n    = sda_o;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    ev_start = 1'b0;
    ev_fail  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        scl_n = 1'b1;
        sda_n = 1'b1;
        if (start_req && tick) begin
          cnt_clr = 1'b1;
          if (sda_in) begin
            nxt   = ST_SETUP;
            sda_n = 1'b0;
          end else begin
            nxt   = ST_RLOW;
            scl_n = 1'b0;
          end
        end
      end
      ST_RLOW: begin
        if (tick) begin
          nxt     = ST_RHIGH;
          scl_n   = 1'b1;
          cnt_inc = 1'b1;
        end
      end
      ST_RHIGH: begin
        if (tick) begin
          if (sda_in) begin
            nxt   = ST_SETUP;
            sda_n = 1'b0;
          end else if (at_limit) begin
            nxt     = ST_DRAIN;
            ev_fail = 1'b1;
          end else begin
            nxt   = ST_RLOW;
            scl_n = 1'b0;
          end
        end
      end
      ST_SETUP: begin
        if (tick) begin
          nxt      = ST_OWN;
          scl_n    = 1'b0;
          ev_start = 1'b1;
        end
      end
      ST_OWN: begin
        if (!start_req) begin
          nxt   = ST_IDLE;
          scl_n = 1'b1;
          sda_n = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!start_req) nxt = ST_IDLE;
      end
      default: begin
        nxt   = ST_IDLE;
        scl_n = 1'b1;
        sda_n = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      scl_o      <= 1'b1;
      sda_o      <= 1'b1;
      start_done <= 1'b0;
      req_clr    <= 1'b0;
    end else begin
      state      <= nxt;
      scl_o      <= scl_n;
      sda_o      <= sda_n;
      start_done <= ev_start;
      req_clr    <= ev_fail;
    end
  end
endmodule

// File: rtl/i2c_start_clear.sv
module i2c_start_clear
  import i2c_bc_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned CW = $clog2(MAX_PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_req,
  input  logic sda_in,
  input  logic clr_err,
  input  logic clr_start,
  output logic scl_o,
  output logic sda_o,
  output logic start_req_clr,
  output logic start_done,
  output logic err_flag,
  output logic start_flag
);
  bc_state_t             fsm_state;
  logic [CW-1:0]         pulse_cnt;
  logic                  at_limit, cnt_clr, cnt_inc, ev_start, ev_fail;
  logic [NUM_FLAGS-1:0]  flag_set, flag_clr, flag_q;

  i2c_bc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start_req  (start_req),
    .sda_in     (sda_in),
    .at_limit   (at_limit),
    .cnt_clr    (cnt_clr),
    .cnt_inc    (cnt_inc),
    .ev_start   (ev_start),
    .ev_fail    (ev_fail),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .start_done (start_done),
    .req_clr    (start_req_clr),
    .state      (fsm_state)
  );

  i2c_bc_pulse_cnt #(.MAX_PULSES(MAX_PULSES)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .count    (pulse_cnt),
    .at_limit (at_limit)
  );

  assign flag_set[FLAG_ERR]   = ev_fail;
  assign flag_set[FLAG_START] = ev_fail | ev_start;
  assign flag_clr[FLAG_ERR]   = clr_err;
  assign flag_clr[FLAG_START] = clr_start;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    i2c_bc_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set[g]),
      .clr   (flag_clr[g]),
      .q     (flag_q[g])
    );
  end

  assign err_flag   = flag_q[FLAG_ERR];
  assign start_flag = flag_q[FLAG_START];
endmodule

// File: rtl/i2c_start_clear_chk.sv
module i2c_start_clear_chk
  import i2c_bc_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 9,
  localparam int unsigned CW = $clog2(MAX_PULSES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_o,
  input logic          sda_o,
  input logic          start_req_clr,
  input logic          err_flag,
  input logic          start_flag,
  input logic          clr_err,
  input bc_state_t     fsm_state,
  input logic [CW-1:0] pulse_cnt
);
  p_sda_free_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_RLOW || fsm_state == ST_RHIGH) |-> sda_o);

  p_pulse_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CW'(MAX_PULSES));

  p_fail_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_req_clr |-> (err_flag && start_flag && scl_o && sda_o));

  p_start_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_o) |-> scl_o);

  p_scl_after_sda_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_o) && !sda_o) |-> $past(!sda_o));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> err_flag);
endmodule

bind i2c_start_clear i2c_start_clear_chk #(.MAX_PULSES(MAX_PULSES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_o         (scl_o),
  .sda_o         (sda_o),
  .start_req_clr (start_req_clr),
  .err_flag      (err_flag),
  .start_flag    (start_flag),
  .clr_err       (clr_err),
  .fsm_state     (fsm_state),
  .pulse_cnt     (pulse_cnt)
);

// File: tb/i2c_start_clear_tb_top.sv
`timescale 1ns/1ps
module i2c_start_clear_tb_top;
  localparam int MAXP = 9;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start_req = 1'b0;
  logic clr_err = 1'b0;
  logic clr_start = 1'b0;
  logic sda_in;
  logic scl_o, sda_o, start_req_clr, start_done, err_flag, start_flag;

  always #2 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int rel_after = 0, seen = 0;
  int cyc = 0, tdiv = 0;
  int done_cnt = 0;
  int mon_pulses = 0, last_edge = -1, sda_fall_cyc = 0;
  bit txn_active = 0, started = 0;
  bit scl_prev = 1, sda_prev = 1;
  bit finished = 0;

  typedef struct { int pulses; bit fail; } exp_t;
  exp_t q[$];

  // open-drain bus: stuck device holds SDA low until it has seen rel_after rises
  assign sda_in = (seen >= rel_after) & sda_o;

  i2c_start_clear #(.MAX_PULSES(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
    .sda_in(sda_in), .clr_err(clr_err), .clr_start(clr_start),
    .scl_o(scl_o), .sda_o(sda_o), .start_req_clr(start_req_clr),
    .start_done(start_done), .err_flag(err_flag), .start_flag(start_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // tick generator
  always @(negedge clk) begin
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    tick = (tdiv == TDIV - 1);
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (rst_n && txn_active) begin
      if (scl_o && !scl_prev) begin mon_pulses++; seen++; end
      if (scl_o != scl_prev && !started) begin
        chk(sda_o == 1'b1, "R3 sda released in burst", sda_o, 1);
        if (last_edge >= 0) chk(cyc - last_edge == TDIV, "R3 phase length", cyc - last_edge, TDIV);
        last_edge = cyc;
      end
      if (!sda_o && sda_prev) begin
        chk(scl_o == 1'b1, "R6 sda falls with scl high", scl_o, 1);
        sda_fall_cyc = cyc;
        started = 1;
      end
      if (!scl_o && scl_prev && !sda_o)
        chk(cyc - sda_fall_cyc == TDIV, "R6 start hold", cyc - sda_fall_cyc, TDIV);
      if (start_done) begin
        e = q.pop_front();
        chk(e.fail == 1'b0, "R4 outcome success", 0, e.fail);
        chk(mon_pulses == e.pulses, "R4 pulse count", mon_pulses, e.pulses);
        chk(start_flag == 1'b1, "R7 start_flag set", start_flag, 1);
        chk(err_flag == 1'b0, "R7 err_flag clear", err_flag, 0);
        chk(!scl_o && !sda_o, "R6 scl low after start", scl_o, 0);
        done_cnt++;
      end
      if (start_req_clr) begin
        e = q.pop_front();
        chk(e.fail == 1'b1, "R5 outcome failure", 1, e.fail);
        chk(mon_pulses == e.pulses, "R5 pulse count", mon_pulses, e.pulses);
        chk(err_flag && start_flag, "R5 both flags", {err_flag, start_flag}, 3);
        chk(scl_o && sda_o, "R5 lines released", {scl_o, sda_o}, 3);
        start_req = 1'b0;
        done_cnt++;
      end
    end
    scl_prev = scl_o;
    sda_prev = sda_o;
  end

  task automatic run_txn(input int k);
    exp_t e;
    int d0;
    e.fail   = (k > MAXP);
    e.pulses = e.fail ? MAXP : k;
    q.push_back(e);
    @(negedge clk);
    rel_after = k; seen = 0; mon_pulses = 0; last_edge = -1; started = 0;
    txn_active = 1;
    start_req  = 1'b1;
    d0 = done_cnt;
    while (done_cnt == d0) @(negedge clk);
    if (!e.fail) begin
      repeat (6) @(negedge clk);
      chk(!scl_o && !sda_o, "R8 bus held after start", {scl_o, sda_o}, 0);
      start_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(scl_o && sda_o, "R8 released on drop", {scl_o, sda_o}, 3);
    end else begin
      repeat (3 * TDIV) @(negedge clk);
      chk(scl_o && sda_o, "R5 no start after failure", {scl_o, sda_o}, 3);
    end
    txn_active = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    clr_err = 1'b1; clr_start = 1'b1;
    @(negedge clk);
    clr_err = 1'b0; clr_start = 1'b0;
    @(negedge clk);
    chk(!err_flag && !start_flag, "R7 w1c clears", {err_flag, start_flag}, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(scl_o && sda_o, "R1 lines in reset", {scl_o, sda_o}, 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl_o && sda_o, "R1 lines after reset", {scl_o, sda_o}, 3);
    chk(!err_flag && !start_flag && !start_req_clr && !start_done, "R1 flags after reset",
        {err_flag, start_flag, start_req_clr, start_done}, 0);

    run_txn(0);                 // R2 free bus, immediate START
    clear_flags();
    run_txn(3);                 // R4 short recovery
    clear_flags();
    run_txn(MAXP);              // R4 last possible pulse
    clear_flags();
    run_txn(MAXP + 1);          // R5 failure
    repeat (20) @(negedge clk);
    chk(err_flag && start_flag, "R7 flags sticky", {err_flag, start_flag}, 3);
    clear_flags();
    run_txn(50);                // R5 failure, never releases
    clear_flags();

    // R7 set and clear in the same cycle: clear held through the transfer
    @(negedge clk);
    clr_start = 1'b1;
    run_txn(1);
    chk(start_flag == 1'b0, "R7 clear after set", start_flag, 0);
    clr_start = 1'b0;
    clear_flags();

    chk(q.size() == 0, "R4 scoreboard drained", q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule